// File: doc/BRIEF.md
# Dual-Channel Interval Timer

This peripheral holds two independent 32-bit counting channels behind a small register bus. Each channel has a control word, a load value and a live count. Software places a start value in the load register and pulses the load bit to copy it into the counter. It then picks a direction and an optional automatic reload, and enables the channel. When the counter wraps past its terminal value, the channel raises a sticky status flag. A single interrupt line reports a flag that is raised on any channel whose interrupt enable is set.

A typical use pairs the channels. One counts down with reload to give a periodic tick, or counts down without reload to give a single event at a chosen delay. The other counts up freely as a time base that software reads. The acknowledge idiom is read-then-write-back: writing a one to the status bit clears it, and writing a zero leaves it alone.

The bus is single-cycle. Writes take effect at the clock edge where the write enable is sampled. Read data is registered and appears one cycle after the read enable.

Top module: `dual_timer`

## Requirements
- R1: Bus decode uses address bit 4 as the channel (0 or 1) and bits 3:2 as the slot: 0 = control, 1 = load, 2 = count, 3 = unused. Bits 1:0 are ignored. Read data appears in the cycle after the read enable. It is zero when no read was requested or when the slot is unused. Reset clears every register, the read data and the interrupt output.
- R2: The control word is 11 bits, zero-extended on read. Bit 0 (mode), bit 2 (external generate), bit 3 (capture) and bit 9 (pulse-width mode) read back exactly as written and have no effect on counting.
- R3: While control bit 5 (load) is 1, the counter takes the load register value on every clock edge and does not count.
- R4: With bit 7 (enable) at 1 and bit 5 at 0, the counter moves by one each cycle. It moves down when bit 1 is 1 and up when bit 1 is 0.
- R5: A down-counting channel expires when it steps from 0. An up-counting channel expires when it steps from all ones. Expiry sets status bit 8 at that edge. Expiry wins over a write-one clear in the same cycle.
- R6: With bit 4 (auto-reload) set, expiry loads the load value and the channel keeps running. An up counter with load value 0 therefore wraps freely.
- R7: With bit 4 clear, expiry lets the count wrap (0 to all ones, or all ones to 0) and clears bit 7, which stops the channel. A control write in the same cycle sets bit 7 to the written value.
- R8: Writing 1 to bit 8 clears the status flag. Writing 0 leaves it unchanged.
- R9: With bit 7 at 0 and bit 5 at 0, the count holds its value.
- R10: A control write with bit 10 (enable-all) set to either channel sets bit 7 of both channels.
- R11: The interrupt output is registered. It is 1 in the cycle after some channel had both bit 8 and bit 6 (interrupt enable) set, and 0 otherwise.
- R12: Reading the count slot returns the counter value live at the read-enable edge, so back-to-back reads of a running up counter differ by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an expiry that lands in the same cycle as a write-one acknowledge, together with the wrap of an up counter with reload. Reaching the wrap naively would take 2^32 cycles. The bench runs a short reload period and issues acknowledge writes on eight consecutive cycles, so at least one of them collides with an expiry. For the free-running case, it preloads the up counter a few steps below all ones, then rewrites the load register to zero while the channel runs, so that the wrap and the reload of zero happen within a handful of cycles. A behavioural model checks the read data and the interrupt on every clock.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int CTL_W  = 11;
  localparam int B_MODE = 0;
  localparam int B_DOWN = 1;
  localparam int B_GEN  = 2;
  localparam int B_CAPT = 3;
  localparam int B_ARLD = 4;
  localparam int B_LOAD = 5;
  localparam int B_IEN  = 6;
  localparam int B_EN   = 7;
  localparam int B_STAT = 8;
  localparam int B_PWM  = 9;
  localparam int B_ALL  = 10;

  typedef enum logic [1:0] {
    SL_CTRL  = 2'd0,
    SL_LOAD  = 2'd1,
    SL_COUNT = 2'd2,
    SL_NONE  = 2'd3
  } slot_e;
endpackage

// File: rtl/dtmr_chan.sv
module dtmr_chan
  import dtmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic             ld_we,
  input  logic             en_all,
  input  logic [W-1:0]     wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [W-1:0]     ld_q,
  output logic [W-1:0]     cnt_q,
  output logic             expire
);
  localparam logic [W-1:0] ALL1 = '1;

  logic             run;
  logic [W-1:0]     step;
  logic [CTL_W-1:0] ctl_nxt;

  assign run    = ctl_q[B_EN] & ~ctl_q[B_LOAD];
  assign step   = ctl_q[B_DOWN] ? cnt_q - 1'b1 : cnt_q + 1'b1;
  assign expire = run & (ctl_q[B_DOWN] ? (cnt_q == '0) : (cnt_q == ALL1));

  always_comb begin
    ctl_nxt = ctl_q;
    if (expire && !ctl_q[B_ARLD]) ctl_nxt[B_EN] = 1'b0;
    if (ctl_we) begin
      ctl_nxt         = wdata[CTL_W-1:0];
      ctl_nxt[B_STAT] = ctl_q[B_STAT] & ~wdata[B_STAT];
    end
    if (en_all) ctl_nxt[B_EN] = 1'b1;
    if (expire) ctl_nxt[B_STAT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      ld_q  <= '0;
      cnt_q <= '0;
    end else begin
      ctl_q <= ctl_nxt;
      if (ld_we) ld_q <= wdata;
      if (ctl_q[B_LOAD]) cnt_q <= ld_q;
      else if (run) cnt_q <= (expire && ctl_q[B_ARLD]) ? ld_q : step;
    end
  end
endmodule

// File: rtl/dtmr_rdmux.sv
module dtmr_rdmux
  import dtmr_pkg::*;
#(
  parameter int W   = 32,
  parameter int NCH = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      re,
  input  logic                      chan,
  input  slot_e                     slot,
  input  logic [NCH-1:0][CTL_W-1:0] ctl_v,
  input  logic [NCH-1:0][W-1:0]     ld_v,
  input  logic [NCH-1:0][W-1:0]     cnt_v,
  output logic [W-1:0]              rdata
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    unique case (slot)
      SL_CTRL:  sel = {{(W-CTL_W){1'b0}}, ctl_v[chan]};
      SL_LOAD:  sel = ld_v[chan];
      SL_COUNT: sel = cnt_v[chan];
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= re ? sel : '0;
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [4:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  input  logic         bus_we,
  input  logic         bus_re,
  output logic [W-1:0] bus_rdata,
  output logic         irq
);
  localparam int NCH = 2;

  slot_e                     slot;
  logic                      chan;
  logic                      en_all;
  logic [NCH-1:0][CTL_W-1:0] ctl_v;
  logic [NCH-1:0][W-1:0]     ld_v;
  logic [NCH-1:0][W-1:0]     cnt_v;
  logic [NCH-1:0]            exp_v;
  logic [NCH-1:0]            pend;

  assign slot   = slot_e'(bus_addr[3:2]);
  assign chan   = bus_addr[4];
  assign en_all = bus_we & (slot == SL_CTRL) & bus_wdata[B_ALL];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = (chan == (c != 0));

    dtmr_chan #(.W(W)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .ctl_we(bus_we & hit & (slot == SL_CTRL)),
      .ld_we (bus_we & hit & (slot == SL_LOAD)),
      .en_all(en_all),
      .wdata (bus_wdata),
      .ctl_q (ctl_v[c]),
      .ld_q  (ld_v[c]),
      .cnt_q (cnt_v[c]),
      .expire(exp_v[c])
    );

    assign pend[c] = ctl_v[c][B_STAT] & ctl_v[c][B_IEN];
  end

  dtmr_rdmux #(.W(W), .NCH(NCH)) u_rd (
    .clk  (clk),
    .rst  (rst),
    .re   (bus_re),
    .chan (chan),
    .slot (slot),
    .ctl_v(ctl_v),
    .ld_v (ld_v),
    .cnt_v(cnt_v),
    .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |pend;
  end
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
  import dtmr_pkg::*;
#(
  parameter int W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_we,
  input logic                irq,
  input logic [1:0][CTL_W-1:0] ctl_v,
  input logic [1:0][W-1:0]   ld_v,
  input logic [1:0][W-1:0]   cnt_v,
  input logic [1:0]          exp_v
);
  logic any_pend;
  assign any_pend = (ctl_v[0][B_STAT] & ctl_v[0][B_IEN]) |
                    (ctl_v[1][B_STAT] & ctl_v[1][B_IEN]);

  a_r11_irq_high: assert property (@(posedge clk) disable iff (rst)
    any_pend |=> irq);
  a_r11_irq_low: assert property (@(posedge clk) disable iff (rst)
    !any_pend |=> !irq);

  for (genvar c = 0; c < 2; c++) begin : g_chk
    a_r3_load_forces: assert property (@(posedge clk) disable iff (rst)
      ctl_v[c][B_LOAD] |=> cnt_v[c] == $past(ld_v[c]));
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
      (!ctl_v[c][B_EN] && !ctl_v[c][B_LOAD]) |=> $stable(cnt_v[c]));
    a_r5_expiry_flags: assert property (@(posedge clk) disable iff (rst)
      exp_v[c] |=> ctl_v[c][B_STAT]);
    a_r7_single_stops: assert property (@(posedge clk) disable iff (rst)
      (exp_v[c] && !ctl_v[c][B_ARLD] && !bus_we) |=> !ctl_v[c][B_EN]);
    a_r4_down_step: assert property (@(posedge clk) disable iff (rst)
      (ctl_v[c][B_EN] && !ctl_v[c][B_LOAD] && ctl_v[c][B_DOWN] && cnt_v[c] != '0)
      |=> cnt_v[c] == $past(cnt_v[c]) - 1'b1);
  end
endmodule

bind dual_timer dtmr_checker #(.W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .bus_we(bus_we),
  .irq   (irq),
  .ctl_v (ctl_v),
  .ld_v  (ld_v),
  .cnt_v (cnt_v),
  .exp_v (exp_v)
);

// File: tb/dual_timer_bench.sv
module dual_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    live = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  dual_timer u_dual_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference
  logic [10:0] m_ctl [2];
  logic [31:0] m_ld  [2];
  logic [31:0] m_cnt [2];
  logic [31:0] m_rdata;
  logic        m_irq;

  always @(posedge clk) begin
    logic [10:0] nc;
    logic [31:0] nn;
    bit          ex;
    int          ch;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin m_ctl[i] = '0; m_ld[i] = '0; m_cnt[i] = '0; end
      m_rdata = '0; m_irq = 0;
    end else begin
      ch = bus_addr[4];
      if (!bus_re) m_rdata = 0;
      else case (bus_addr[3:2])
        2'd0: m_rdata = {21'd0, m_ctl[ch]};
        2'd1: m_rdata = m_ld[ch];
        2'd2: m_rdata = m_cnt[ch];
        default: m_rdata = 0;
      endcase
      m_irq = (m_ctl[0][8] && m_ctl[0][6]) || (m_ctl[1][8] && m_ctl[1][6]);
      for (int i = 0; i < 2; i++) begin
        nc = m_ctl[i]; nn = m_cnt[i]; ex = 0;
        if (m_ctl[i][5]) nn = m_ld[i];
        else if (m_ctl[i][7]) begin
          if (m_ctl[i][1]) begin ex = (m_cnt[i] == 0); nn = m_cnt[i] - 1; end
          else begin ex = (m_cnt[i] == 32'hFFFF_FFFF); nn = m_cnt[i] + 1; end
          if (ex) begin
            if (m_ctl[i][4]) nn = m_ld[i];
            else nc[7] = 0;
          end
        end
        if (bus_we && ch == i && bus_addr[3:2] == 0)
          nc = {bus_wdata[10:9], m_ctl[i][8] & ~bus_wdata[8], bus_wdata[7:0]};
        if (bus_we && bus_addr[3:2] == 0 && bus_wdata[10]) nc[7] = 1;
        if (ex) nc[8] = 1;
        if (bus_we && ch == i && bus_addr[3:2] == 1) m_ld[i] = bus_wdata;
        m_ctl[i] = nc; m_cnt[i] = nn;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      chk({cur_req, " rdata vs model"}, bus_rdata, m_rdata);
      chk({cur_req, " irq vs model"}, {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a; bus_re = 1;
    @(negedge clk);
    bus_re = 0; v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, a, b;
    repeat (3) @(negedge clk);
    rst = 0; live = 1;
    @(negedge clk);

    cur_req = "R1";
    rd(5'h00, v); chk("R1 reset ctrl0", v, 0);
    rd(5'h18, v); chk("R1 reset count1", v, 0);
    chk("R1 reset irq", {31'd0, irq}, 0);

    cur_req = "R2";
    wr(5'h00, 32'h20D);
    rd(5'h00, v); chk("R2 stored bits readback", v, 32'h20D);
    rd(5'h08, v); chk("R2 stored bits do not count", v, 0);

    cur_req = "R3";
    wr(5'h04, 5); wr(5'h00, 32'h20); idle(1);
    rd(5'h08, v); chk("R3 load forces count", v, 5);

    cur_req = "R7";
    wr(5'h00, 32'hC2); idle(10);
    rd(5'h00, v); chk("R7 single shot stops, R5 status", v, 32'h142);
    rd(5'h08, v); chk("R7 count wrapped", v, 32'hFFFF_FFFF);
    chk("R11 irq raised", {31'd0, irq}, 1);

    cur_req = "R8";
    wr(5'h00, 32'h042);
    rd(5'h00, v); chk("R8 write zero keeps status", v, 32'h142);
    wr(5'h00, 32'h142); idle(1);
    rd(5'h00, v); chk("R8 write one clears", v, 32'h042);
    chk("R11 irq dropped", {31'd0, irq}, 0);

    cur_req = "R6";
    wr(5'h04, 3); wr(5'h00, 32'h20); wr(5'h00, 32'hD2); idle(20);
    rd(5'h00, v); chk("R6 periodic keeps running", v & 32'h190, 32'h190);
    rd(5'h08, v); chk("R6 count within period", {31'd0, v > 3}, 0);

    cur_req = "R5";
    for (int k = 0; k < 8; k++) wr(5'h00, 32'h1D2);
    idle(3);

    cur_req = "R9";
    wr(5'h00, 32'h052);
    rd(5'h08, a); idle(5); rd(5'h08, b);
    chk("R9 disabled count holds", b, a);

    cur_req = "R10";
    wr(5'h14, 100); wr(5'h10, 32'h20); wr(5'h10, 0);
    wr(5'h00, 32'h400);
    rd(5'h00, v); chk("R10 enable-all ch0", v & 32'h80, 32'h80);
    rd(5'h10, v); chk("R10 enable-all ch1", v, 32'h80);

    cur_req = "R12";
    rd(5'h18, a); rd(5'h18, b);
    chk("R12 live count, R4 up step", b, a + 1);

    cur_req = "R6";
    wr(5'h14, 32'hFFFF_FFFC); wr(5'h10, 32'h20); idle(1);
    wr(5'h10, 32'h90); wr(5'h14, 0); idle(10);
    rd(5'h10, v); chk("R6 up wrap, R5 status", v, 32'h190);
    rd(5'h18, v); chk("R6 free run after zero reload", {31'd0, v < 20}, 1);
    chk("R11 irq gated by enable", {31'd0, irq}, 0);

    idle(2);
    finish_run();
  end
endmodule